// File: doc/BRIEF.md
# Acknowledged Multi-Bit Clock-Domain Transfer

This block carries one data word at a time from a sending clock domain to a receiving clock domain with no fixed relation between them. When the sender asks to send while it is ready, the word is copied into a holding register and a single request line flips. Only that request line goes through a two-stage synchronizer into the receiving domain. There, a change on the synchronized line gives a one-cycle enable. On that enable the receiver captures the holding register, which has not been synchronized but is stable, and flips an acknowledge line.

The acknowledge line goes back through its own two-stage synchronizer. In the sending domain, a change on it ends the busy period and raises ready again. The loop is closed, so no word is sent before the previous one has been captured. This holds whatever the frequency ratio or phase of the two clocks. The receiver is assumed to accept every word, so it has no throttle input.

Top module: `ack_word_bridge`

## Requirements
- R1: While either reset is low, and just after it is released, `snd_ready` is 1, `rcv_valid` is 0 and `rcv_word` is all zeros.
- R2: A send is accepted when `snd_req` is 1 at a rising `snd_clk` edge while `snd_ready` is 1. From that edge on, `snd_ready` reads 0.
- R3: Each accepted word appears exactly once on `rcv_word`, in the order it was accepted. Its value is that of `snd_word` at the accepting edge. `rcv_word` changes only in a cycle where `rcv_valid` is 1.
- R4: `rcv_valid` is high for exactly one `rcv_clk` cycle per delivered word.
- R5: `snd_ready` returns to 1 only after the word in flight has been presented on `rcv_word` with `rcv_valid`.
- R6: A `snd_req` while `snd_ready` is 0 is ignored. No extra word is delivered, and the word in flight is not replaced.
- R7: Changes on `snd_word` after the accepting edge have no effect on the delivered word.
- R8: R2 to R7 hold when the receiving clock is faster than, equal to, or slower than the sending clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Sending-domain clock |
| snd_rst_n | input | 1 | Sending-domain active-low reset |
| snd_req | input | 1 | Request to send `snd_word` |
| snd_word | input | DW | Word to send |
| snd_ready | output | 1 | High when a new send will be accepted |
| rcv_clk | input | 1 | Receiving-domain clock |
| rcv_rst_n | input | 1 | Receiving-domain active-low reset |
| rcv_word | output | DW | Last captured word |
| rcv_valid | output | 1 | One-cycle pulse marking a new `rcv_word` |

## Verification
The case that is hardest to reach from the ports is a second request, with a different word, that arrives while the first word is still crossing. The sending-side data bus also changes during that window. The driver makes this happen on purpose in every transfer. After each acceptance it scrambles `snd_word` and pulses `snd_req` again, and it does so before the acknowledge can come back. It repeats this with a receiving clock that is faster, equal and slower, so the acknowledge delay takes many different lengths. The scoreboard catches any word that is replaced, duplicated or extra.

// File: rtl/ack_word_bridge.sv
module ack_word_bridge #(
  parameter int DW = 16
) (
  input  logic          snd_clk,
  input  logic          snd_rst_n,
  input  logic          snd_req,
  input  logic [DW-1:0] snd_word,
  output logic          snd_ready,
  input  logic          rcv_clk,
  input  logic          rcv_rst_n,
  output logic [DW-1:0] rcv_word,
  output logic          rcv_valid
);

  // sending domain
  logic          busy_q, req_tgl_q;
  logic [DW-1:0] hold_q;
  logic [2:0]    ack_sync_q;
  logic          ack_evt, accept;

  assign accept    = snd_req && !busy_q;
  assign ack_evt   = ack_sync_q[1] ^ ack_sync_q[2];
  assign snd_ready = !busy_q;

  // receiving domain
  logic [2:0] req_sync_q;
  logic       ack_tgl_q, req_evt;

  assign req_evt = req_sync_q[1] ^ req_sync_q[2];

  always_ff @(posedge snd_clk or negedge snd_rst_n) begin
    if (!snd_rst_n) begin
      busy_q     <= 1'b0;
      req_tgl_q  <= 1'b0;
      hold_q     <= '0;
      ack_sync_q <= '0;
    end else begin
      ack_sync_q <= {ack_sync_q[1:0], ack_tgl_q};
      if (accept) begin
        busy_q    <= 1'b1;
        req_tgl_q <= ~req_tgl_q;
        hold_q    <= snd_word;
      end else if (ack_evt) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge rcv_clk or negedge rcv_rst_n) begin
    if (!rcv_rst_n) begin
      req_sync_q <= '0;
      ack_tgl_q  <= 1'b0;
      rcv_word   <= '0;
      rcv_valid  <= 1'b0;
    end else begin
      req_sync_q <= {req_sync_q[1:0], req_tgl_q};
      rcv_valid  <= req_evt;
      if (req_evt) begin
        rcv_word  <= hold_q;
        ack_tgl_q <= ~ack_tgl_q;
      end
    end
  end

  assert_busy_until_ack_R5: assert property (@(posedge snd_clk) disable iff (!snd_rst_n)
    (busy_q && !ack_evt) |=> busy_q);

  assert_ignore_busy_req_R6: assert property (@(posedge snd_clk) disable iff (!snd_rst_n)
    busy_q |=> ($stable(req_tgl_q) && $stable(hold_q)));

  assert_accept_drops_ready_R2: assert property (@(posedge snd_clk) disable iff (!snd_rst_n)
    (snd_req && snd_ready) |=> !snd_ready);

  assert_valid_single_R4: assert property (@(posedge rcv_clk) disable iff (!rcv_rst_n)
    rcv_valid |=> !rcv_valid);

  assert_word_only_with_valid_R3: assert property (@(posedge rcv_clk) disable iff (!rcv_rst_n)
    !rcv_valid |-> $stable(rcv_word));

endmodule

// File: tb/test_ack_word_bridge.sv
module test_ack_word_bridge;
  localparam int DW = 16;

  logic          snd_clk = 0, rcv_clk = 0;
  logic          snd_rst_n = 0, rcv_rst_n = 0;
  logic          snd_req = 0;
  logic [DW-1:0] snd_word = '0;
  logic          snd_ready, rcv_valid;
  logic [DW-1:0] rcv_word;

  int  rcv_half = 5;
  int  n_checks = 0, n_fail = 0;
  int  n_sent = 0, n_got = 0;
  bit  done = 0;
  logic [DW-1:0] expq[$];

  always #5 snd_clk = ~snd_clk;
  always #(rcv_half) rcv_clk = ~rcv_clk;

  ack_word_bridge #(.DW(DW)) i_ack_word_bridge (
    .snd_clk(snd_clk), .snd_rst_n(snd_rst_n), .snd_req(snd_req),
    .snd_word(snd_word), .snd_ready(snd_ready),
    .rcv_clk(rcv_clk), .rcv_rst_n(rcv_rst_n),
    .rcv_word(rcv_word), .rcv_valid(rcv_valid));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // monitor: pops the scoreboard on each delivered word (R3, R4, R8)
  logic prev_valid = 0;
  always begin
    @(posedge rcv_clk); #1;
    if (rcv_rst_n) begin
      if (rcv_valid) begin
        chk(!prev_valid, "R4", 1, 0);
        if (expq.size() == 0) chk(0, "R6", rcv_word, -1);
        else begin
          logic [DW-1:0] e;
          e = expq.pop_front();
          chk(rcv_word == e, "R3", rcv_word, e);
        end
        n_got++;
      end
      prev_valid = rcv_valid;
    end
  end

  // ready may rise only after the word was delivered (R5)
  logic prev_ready = 1;
  always begin
    @(posedge snd_clk); #1;
    if (snd_rst_n && !done) begin
      if (snd_ready && !prev_ready) chk(n_got == n_sent, "R5", n_got, n_sent);
      prev_ready = snd_ready;
    end
  end

  task automatic send(input logic [DW-1:0] w);
    while (!snd_ready) @(negedge snd_clk);
    snd_req = 1; snd_word = w;
    expq.push_back(w); n_sent++;
    @(posedge snd_clk); #1;
    chk(snd_ready == 0, "R2", snd_ready, 0);
    @(negedge snd_clk);
    snd_req = 0; snd_word = ~w;           // R7: bus changes while busy
    @(negedge snd_clk);
    snd_req = 1; snd_word = w ^ 16'h5a5a; // R6: request while busy
    @(negedge snd_clk);
    snd_req = 0;
  endtask

  task automatic burst(input int half, input int n, input logic [DW-1:0] seed);
    rcv_half = half;
    for (int i = 0; i < n; i++) send(seed + DW'(i * 16'h1357));
    while (!snd_ready || expq.size() != 0) @(negedge snd_clk);
    repeat (8) @(negedge snd_clk);
    chk(expq.size() == 0, "R8", expq.size(), 0);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL watchdog");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge snd_clk);
    chk(snd_ready == 1, "R1", snd_ready, 1);
    chk(rcv_valid == 0, "R1", rcv_valid, 0);
    chk(rcv_word == 0, "R1", rcv_word, 0);
    snd_rst_n = 1; rcv_rst_n = 1;
    repeat (2) @(negedge snd_clk);
    chk(snd_ready == 1, "R1", snd_ready, 1);
    chk(rcv_valid == 0, "R1", rcv_valid, 0);
    burst(5, 6, 16'h1000);   // equal clocks
    burst(2, 6, 16'h2000);   // faster receiver
    burst(17, 6, 16'h3000);  // slower receiver
    burst(3, 4, 16'hfff0);
    chk(n_got == n_sent, "R3", n_got, n_sent);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule